// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad

This block is an on-chip scratchpad built from a set of parallel storage banks, each one 32-bit word wide. It takes a single access at a time. Each access carries up to one request per lane: an active bit, a byte address and, for writes, a data word. The access is either all reads or all writes. Every byte address is reduced to a word index by dropping its two low bits. The bank is that word index modulo the bank count, and the row inside the bank is the word index divided by the bank count. Consecutive words therefore sit in consecutive banks and wrap around to bank 0.

A bank can deliver or store only one word per clock. If active lanes ask one bank for different words, the block replays the access over several clocks. In each clock, every bank serves its lowest-numbered pending lane, together with every other pending lane that wants the same word. Lanes that share a word are served by broadcast and cost nothing extra. The access therefore takes as many clocks as the largest number of distinct words that any single bank must supply, and never fewer than one.

When the last lane has been served, the block raises a one-cycle completion pulse. With that pulse it presents every lane's read word in that lane's own slot and the number of clocks the access used. The request side uses a valid/ready handshake, and ready stays low while an access is being replayed.

Top module: `spad_banked`

## Requirements
- R1: A lane's word index is its byte address shifted right by 2, so the two low address bits are ignored. Its bank is the word index modulo BANKS and its row is the word index divided by BANKS. The read word of lane i is returned in bits [i*32 +: 32] of `rsp_rdata`.
- R2: If all active lanes hit different banks, `rsp_done` rises exactly 1 clock after the accepting clock, with `rsp_cycles` = 1.
- R3: Different words requested from the same bank are served one per clock. `rsp_cycles` equals the largest number of distinct words asked of any one bank, and `rsp_done` rises that many clocks after acceptance. A word stride of 2 takes 2 clocks, a stride of 32 takes 32 clocks, and any odd stride takes 1 clock.
- R4: Lanes that request the identical word are served together in one clock and do not add to the count.
- R5: If several active lanes write the same word, the data of the highest-numbered of those lanes is the value stored.
- R6: Inactive lanes never change memory, never add to the count, and their `rsp_rdata` slot is zero. An access with no active lane completes with `rsp_cycles` = 1. Every slot of `rsp_rdata` is zero after a write access.
- R7: `req_ready` is high when the block is idle and low from the accepting clock until completion. It is high again in the `rsp_done` cycle. A request presented while `req_ready` is low is ignored.
- R8: `rsp_done` is a single-cycle pulse. `rsp_rdata` and `rsp_cycles` hold their values until the next access is accepted.
- R9: After reset, `req_ready` = 1, `rsp_done` = 0 and `rsp_cycles` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is offered |
| req_ready | output | 1 | The block is idle and can accept an access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*AW | Per-lane byte addresses; lane i is in bits [i*AW +: AW] |
| req_wdata | input | LANES*32 | Per-lane write data; lane i is in bits [i*32 +: 32] |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LANES*32 | Per-lane read words |
| rsp_cycles | output | CW | Number of clocks the access used |

## Verification
The bench builds the block with its defaults: 32 lanes, 32 banks and 32 rows per bank, which gives 12-bit byte addresses. With 32 rows, all 32 lanes can target distinct words inside bank 0, so the full 32-clock worst case can be reached. Strides 1, 2, 3, 4, 5, 7, 16 and 32, full and partial broadcast, a same-word write collision and masked lanes whose inactive addresses would otherwise collide can all be expressed against real storage. During each replay the bench also offers a competing write, to show that it is not taken.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } spad_state_t;

  // Byte address to 32-bit word index: the two low bits select a byte.
  function automatic int unsigned word_index(input int unsigned byte_addr);
    return byte_addr >> 2;
  endfunction

  // Words are striped round-robin over the banks.
  function automatic int unsigned bank_index(input int unsigned word,
                                             input int unsigned banks);
    return word % banks;
  endfunction

  function automatic int unsigned row_index(input int unsigned word,
                                            input int unsigned banks);
    return word / banks;
  endfunction

endpackage

// File: rtl/spad_bank_arb.sv
// Per-bank pick: the lowest pending lane on this bank leads, and every pending
// lane on the same bank and row rides along by broadcast.
module spad_bank_arb #(
  parameter int LANES   = 32,
  parameter int BW      = 5,
  parameter int RW      = 5,
  parameter int DW      = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]         pend,
  input  logic [LANES-1:0][BW-1:0] lane_bank,
  input  logic [LANES-1:0][RW-1:0] lane_row,
  input  logic [LANES-1:0][DW-1:0] lane_wd,
  output logic [LANES-1:0]         served,
  output logic                     any,
  output logic [RW-1:0]            row,
  output logic [DW-1:0]            wdata
);

  logic [LANES-1:0] hit;

  always_comb begin
    hit = '0;
    for (int i = 0; i < LANES; i++)
      hit[i] = pend[i] && (lane_bank[i] == BW'(BANK_ID));
  end

  always_comb begin
    any = 1'b0;
    row = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hit[i] && !any) begin
        any = 1'b1;
        row = lane_row[i];
      end
    end
  end

  // Ascending scan: the highest served lane's data is the one that is kept.
  always_comb begin
    served = '0;
    wdata  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hit[i] && (lane_row[i] == row)) begin
        served[i] = 1'b1;
        wdata     = lane_wd[i];
      end
    end
  end

endmodule

// File: rtl/spad_bank_mem.sv
// One bank: a word-wide register array with an asynchronous read port.
module spad_bank_mem #(
  parameter int ROWS = 32,
  parameter int DW   = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  assign rdata = mem[row];

endmodule

// File: rtl/spad_banked.sv
module spad_banked #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(BANKS * ROWS * 4),
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LANES-1:0]  req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic              rsp_done,
  output logic [LANES*DW-1:0] rsp_rdata,
  output logic [CW-1:0]     rsp_cycles
);

  import spad_pkg::*;

  spad_state_t st;
  logic                     wr_q;
  logic [LANES-1:0]         pend;
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0][DW-1:0] wd_q;
  logic [LANES-1:0][DW-1:0] rd_q;
  logic [CW-1:0]            cnt;
  logic                     done_q;

  // Named events for the checker.
  logic             busy;
  logic             accept;
  logic [LANES-1:0] served;
  logic [LANES-1:0] pend_next;
  logic             last_step;

  logic [LANES-1:0][BW-1:0] lane_bank;
  logic [LANES-1:0][RW-1:0] lane_row;
  logic [BANKS-1:0][LANES-1:0] bank_served;
  logic [BANKS-1:0][DW-1:0]    bank_rd;

  assign busy      = (st == ST_BUSY);
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign pend_next = pend & ~served;
  assign last_step = busy && (pend_next == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bank[i] = BW'(bank_index(word_index(32'(addr_q[i])), int'(BANKS)));
    assign lane_row[i]  = RW'(row_index(word_index(32'(addr_q[i])), int'(BANKS)));
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          b_any;
    logic [RW-1:0] b_row;
    logic [DW-1:0] b_wd;

    spad_bank_arb #(
      .LANES(LANES), .BW(BW), .RW(RW), .DW(DW), .BANK_ID(b)
    ) u_arb (
      .pend     (pend),
      .lane_bank(lane_bank),
      .lane_row (lane_row),
      .lane_wd  (wd_q),
      .served   (bank_served[b]),
      .any      (b_any),
      .row      (b_row),
      .wdata    (b_wd)
    );

    spad_bank_mem #(.ROWS(ROWS), .DW(DW)) u_mem (
      .clk  (clk),
      .we   (busy && wr_q && b_any),
      .row  (b_row),
      .wdata(b_wd),
      .rdata(bank_rd[b])
    );
  end

  // Banks serve disjoint lane sets, so an OR merges them.
  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | bank_served[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wr_q   <= 1'b0;
      pend   <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st   <= ST_BUSY;
        wr_q <= req_write;
        pend <= req_active;
        cnt  <= '0;
        rd_q <= '0;
      end else if (busy) begin
        pend <= pend_next;
        cnt  <= cnt + 1'b1;
        for (int i = 0; i < LANES; i++)
          if (served[i] && !wr_q) rd_q[i] <= bank_rd[lane_bank[i]];
        if (last_step) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  assign rsp_done   = done_q;
  assign rsp_rdata  = rd_q;
  assign rsp_cycles = cnt;

endmodule

// File: rtl/spad_banked_chk.sv
module spad_banked_chk #(
  parameter int LANES = 32,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [CW-1:0]    rsp_cycles,
  input logic             busy,
  input logic             accept,
  input logic [LANES-1:0] pend,
  input logic [LANES-1:0] served
);

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(busy)); // R8
  AST_CYCLES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_cycles != '0 && rsp_cycles <= CW'(LANES))); // R3
  AST_SERVE_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend != '0) |-> (served != '0)); // R3
  AST_SERVE_PENDING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((served & ~pend) == '0)); // R6

endmodule

bind spad_banked spad_banked_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_cycles(rsp_cycles),
  .busy      (busy),
  .accept    (accept),
  .pend      (pend),
  .served    (served)
);

// File: tb/spad_banked_tb.sv
module spad_banked_tb;

  localparam int LANES = 32;
  localparam int BANKS = 32;
  localparam int ROWS  = 32;
  localparam int DW    = 32;
  localparam int AW    = 12;
  localparam int CW    = 6;
  localparam int WORDS = BANKS * ROWS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [LANES-1:0] req_active;
  logic [LANES*AW-1:0] req_addr;
  logic [LANES*DW-1:0] req_wdata;
  logic rsp_done;
  logic [LANES*DW-1:0] rsp_rdata;
  logic [CW-1:0] rsp_cycles;

  spad_banked #(.LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_active(req_active), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_cycles(rsp_cycles)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [WORDS];
  int            a_addr [LANES];
  logic [DW-1:0] a_wd   [LANES];
  logic [LANES-1:0] a_act;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: byte address >> 2 gives the word; word mod BANKS gives the bank.
  function automatic int lane_word(input int i);
    return (a_addr[i] / 4) % WORDS;
  endfunction

  function automatic int ref_degree();
    int worst = 1;
    for (int b = 0; b < BANKS; b++) begin
      int seen[$];
      seen.delete();
      for (int i = 0; i < LANES; i++) begin
        if (a_act[i] && (lane_word(i) % BANKS) == b) begin
          bit dup = 0;
          foreach (seen[k]) if (seen[k] == lane_word(i)) dup = 1;
          if (!dup) seen.push_back(lane_word(i));
        end
      end
      if (seen.size() > worst) worst = seen.size();
    end
    return worst;
  endfunction

  // Word pattern base + i*stride, with a varying byte offset in the low bits.
  task automatic set_pattern(input int base, input int stride,
                             input logic [LANES-1:0] act);
    for (int i = 0; i < LANES; i++) begin
      a_addr[i] = (((base + i * stride) % WORDS) * 4) + (i % 4);
      a_wd[i]   = 32'h5A00_0000 ^ (i * 32'h0101_0037) ^ (base * 32'h10);
    end
    a_act = act;
  endtask

  task automatic run(input bit wr, input bit noise, input string req);
    int d;
    logic [DW-1:0] exp_rd [LANES];
    d = ref_degree();
    for (int i = 0; i < LANES; i++)
      exp_rd[i] = (!wr && a_act[i]) ? ref_mem[lane_word(i)] : '0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before request", req_ready, 1);
    req_valid  = 1'b1;
    req_write  = wr;
    req_active = a_act;
    for (int i = 0; i < LANES; i++) begin
      req_addr[i*AW +: AW]  = AW'(a_addr[i]);
      req_wdata[i*DW +: DW] = a_wd[i];
    end
    @(negedge clk);
    req_valid = noise;
    if (noise) begin
      req_write  = 1'b1;
      req_active = '1;
      req_addr   = '0;
      req_wdata  = {LANES{32'hDEAD_BEEF}};
    end
    for (int k = 1; k <= d; k++) begin
      chk(rsp_done == 1'b0, req, "done early", rsp_done, 0);
      chk(req_ready == 1'b0, "R7", "ready while replaying", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rsp_done == 1'b1, req, "done at degree", rsp_done, 1);
    chk(rsp_cycles == CW'(d), req, "cycle count", rsp_cycles, d);
    chk(req_ready == 1'b1, "R7", "ready with done", req_ready, 1);
    begin
      int bad = -1;
      for (int i = LANES - 1; i >= 0; i--)
        if (rsp_rdata[i*DW +: DW] !== exp_rd[i]) bad = i;
      if (bad < 0) chk(1'b1, req, "read slots", 0, 0);
      else chk(1'b0, req, $sformatf("read slot lane %0d", bad),
               rsp_rdata[bad*DW +: DW], exp_rd[bad]);
    end
    if (wr)
      for (int i = 0; i < LANES; i++)
        if (a_act[i]) ref_mem[lane_word(i)] = a_wd[i];
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8", "done single pulse", rsp_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_active = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    chk(rsp_done == 1'b0, "R9", "done after reset", rsp_done, 0);
    chk(rsp_cycles == '0, "R9", "cycles after reset", rsp_cycles, 0);

    // Fill all storage with stride-1 writes (R2: one clock each).
    for (int r = 0; r < ROWS; r++) begin
      set_pattern(r * BANKS, 1, '1);
      for (int i = 0; i < LANES; i++) a_wd[i] = 32'hC0DE_0000 + (r * BANKS + i) * 32'h0001_0003;
      run(1'b1, 1'b0, "R2");
    end

    set_pattern(0, 1, '1);    run(1'b0, 1'b0, "R1");
    set_pattern(96, 1, '1);   run(1'b0, 1'b0, "R2");
    set_pattern(0, 2, '1);    run(1'b0, 1'b0, "R3");   // stride 2: 2 clocks
    set_pattern(3, 32, '1);   run(1'b0, 1'b1, "R3");   // stride 32: 32 clocks, noise R7
    set_pattern(1, 3, '1);    run(1'b0, 1'b0, "R3");   // odd strides: 1 clock
    set_pattern(7, 5, '1);    run(1'b0, 1'b0, "R3");
    set_pattern(9, 7, '1);    run(1'b0, 1'b0, "R3");
    set_pattern(0, 4, '1);    run(1'b0, 1'b1, "R3");
    set_pattern(2, 16, '1);   run(1'b0, 1'b0, "R3");
    // Noise write to word 0 must not have landed (R7).
    set_pattern(0, 1, '1);    run(1'b0, 1'b0, "R7");

    // Broadcast: every lane on one word (R4), then two words in one bank.
    set_pattern(77, 0, '1);   run(1'b0, 1'b0, "R4");
    set_pattern(5, 0, '1);
    for (int i = 16; i < LANES; i++) a_addr[i] = 37 * 4;
    run(1'b0, 1'b0, "R4");
    // Mixed: words 40,40,72,104 on bank 8 plus a stride of 1 elsewhere.
    set_pattern(200, 1, '1);
    a_addr[0] = 40 * 4; a_addr[1] = 40 * 4 + 2; a_addr[2] = 72 * 4; a_addr[3] = 104 * 4;
    run(1'b0, 1'b0, "R3");

    // Same-word write collision: highest lane wins (R5).
    set_pattern(100, 0, '1);  run(1'b1, 1'b0, "R5");
    set_pattern(100, 0, '1);  run(1'b0, 1'b0, "R5");

    // Masked write, then a full read-back of those words (R6).
    set_pattern(300, 1, 32'h5555_5555);
    for (int i = 0; i < LANES; i++) a_wd[i] = 32'hBAD0_0000 + i;
    run(1'b1, 1'b0, "R6");
    set_pattern(300, 1, '1);  run(1'b0, 1'b0, "R6");
    // Inactive lanes parked on bank 0 neither count nor fill their slots.
    set_pattern(1, 1, 32'h0000_FFFF);
    for (int i = 16; i < LANES; i++) a_addr[i] = (i - 16) * 32 * 4;
    run(1'b0, 1'b0, "R6");
    set_pattern(0, 32, '0);   run(1'b0, 1'b0, "R6");
    // Write access leaves all read slots zero (R6); R8 hold checked by next read.
    set_pattern(500, 1, '1);  run(1'b1, 1'b0, "R6");
    chk(rsp_cycles == CW'(1), "R8", "cycles held after done", rsp_cycles, 1);
    set_pattern(500, 1, '1);  run(1'b0, 1'b0, "R1");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule